// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs after a translation cache miss. It translates a 32-bit virtual address by walking a two-level tree of 4-byte entries held in memory. A root input holds the physical page number of the top-level directory. Software sets it on each context switch. The walker reads one directory entry and then one leaf entry, through a memory port that allows one outstanding access. It finishes with one of two results: a refill record for the translation cache, or a page-not-present fault that names the level where the walk stopped.

Bit 0 of every entry is the present flag. When it is clear, every other bit of that entry is ignored. Bits 31:12 hold a physical page number. Bit 1 marks the page writable and bit 2 marks it user-accessible. Bit 5 is the accessed flag and bit 6 is the dirty flag. Virtual bits 31:22 pick the directory slot, bits 21:12 pick the leaf slot, and an entry's address is its table base plus four times its index. On a successful walk the walker sets the accessed flag in the leaf, and also the dirty flag for a write access. It writes the leaf back only when that changes it.

The control is a state machine with six states:
- IDLE goes to DIR_RD on a request.
- DIR_RD goes to TBL_RD when the directory entry is present, or to FAULT when it is absent.
- TBL_RD goes to FAULT when the leaf is absent, to LEAF_WB when the flags must change, or otherwise to DONE.
- LEAF_WB goes to DONE once its write is acknowledged.
- DONE and FAULT each last one cycle and return to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, mem_req, done_valid and fault_valid are all low.
- R2: In IDLE, a high req_valid starts a walk and busy is high from the next cycle until the cycle after the result. A req_valid seen while busy is ignored and starts no walk.
- R3: The first access is a read at address {root_ppn, vaddr[31:22], 2'b00}.
- R4: After a present directory entry, the second access is a read at address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R5: A directory entry with bit 0 clear ends the walk with fault_valid and fault_level=0, whatever its other bits hold, and no leaf read is made.
- R6: A leaf entry with bit 0 clear ends the walk with fault_valid and fault_level=1, whatever its other bits hold, and no write is made.
- R7: A successful walk pulses done_valid with res_vpn=vaddr[31:12], res_ppn=leaf[31:12], res_writable=leaf bit 1 and res_user=leaf bit 2.
- R8: On success, the leaf is written back to its own address with bit 5 (accessed) set.
- R9: A write access also sets bit 6 (dirty) in the written-back leaf, and res_dirty reports the final value of bit 6.
- R10: The write-back is skipped when bit 5 is already set and, for a write access, bit 6 is also already set.
- R11: mem_req, mem_we, mem_addr and mem_wdata stay stable from the cycle mem_req rises until the cycle mem_ack is seen. A transfer completes only in a cycle where both are high.
- R12: done_valid and fault_valid are never high together, and each lasts exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_ppn | input | 20 | Physical page number of the top-level directory |
| req_valid | input | 1 | Start a walk (taken only in IDLE) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write (sets dirty) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf entry for the write-back |
| mem_ack | input | 1 | Memory accepts/completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done_valid | output | 1 | One-cycle pulse: refill record valid |
| fault_valid | output | 1 | One-cycle pulse: page-not-present |
| fault_level | output | 1 | 0 = directory absent, 1 = leaf absent |
| res_vpn | output | 20 | Virtual page number of the walk |
| res_ppn | output | 20 | Physical page number for the refill |
| res_writable | output | 1 | Leaf writable flag |
| res_user | output | 1 | Leaf user flag |
| res_dirty | output | 1 | Leaf dirty flag after update |

## Verification
Hard to reach from the ports:
- The choice between skipping and performing the write-back depends on the history of the leaf in memory. The stimulus therefore revisits one page with a read and then a write, and again with both flags already set, so the same entry reaches every write-back case.
- A request that arrives during a walk is dropped inside the machine and leaves no trace of its own. To show this, a second request is pulsed while the first is still fetching its leaf. The check then confirms that exactly one result appears, that no extra reads occur, and that busy stays low afterwards.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_LEAF_WB,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    localparam int unsigned ENT_PRESENT = 0;
    localparam int unsigned ENT_WRITE   = 1;
    localparam int unsigned ENT_USER    = 2;
    localparam int unsigned ENT_ACC     = 5;
    localparam int unsigned ENT_DIRTY   = 6;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic                       leaf_level,
    input  logic [ADDR_W-OFFS_W-1:0]   root_pn,
    input  logic [ADDR_W-OFFS_W-1:0]   dir_pn,
    input  logic [ADDR_W-OFFS_W-1:0]   vpn,
    output logic [ADDR_W-1:0]          ent_addr
);
    localparam int PN_W  = ADDR_W - OFFS_W;
    localparam int ENT_LG = OFFS_W - IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = vpn[PN_W-1 -: IDX_W];
    assign tbl_idx = vpn[IDX_W-1:0];

    always_comb begin
        if (leaf_level)
            ent_addr = {dir_pn, tbl_idx, {ENT_LG{1'b0}}};
        else
            ent_addr = {root_pn, dir_idx, {ENT_LG{1'b0}}};
    end

endmodule

// File: rtl/ptw_entry_upd.sv
module ptw_entry_upd
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input  logic [ADDR_W-1:0]        ent,
    input  logic                     is_write,
    output logic                     present,
    output logic [ADDR_W-OFFS_W-1:0] pn,
    output logic [ADDR_W-1:0]        upd,
    output logic                     wb_needed
);
    assign present = ent[ENT_PRESENT];
    assign pn      = ent[ADDR_W-1:OFFS_W];

    always_comb begin
        upd = ent;
        upd[ENT_ACC] = 1'b1;
        if (is_write)
            upd[ENT_DIRTY] = 1'b1;
        wb_needed = (upd != ent);
    end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_ack,
    input  logic        ent_present,
    input  logic        wb_needed,
    output walk_state_e state
);
    walk_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_DIR_RD;
            ST_DIR_RD:  if (mem_ack)   state_nx = ent_present ? ST_TBL_RD : ST_FAULT;
            ST_TBL_RD:  if (mem_ack) begin
                            if (!ent_present)   state_nx = ST_FAULT;
                            else if (wb_needed) state_nx = ST_LEAF_WB;
                            else                state_nx = ST_DONE;
                        end
            ST_LEAF_WB: if (mem_ack)   state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            ST_FAULT:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-OFFS_W-1:0]   root_ppn,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic                       req_write,
    output logic                       busy,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [ADDR_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [ADDR_W-1:0]          mem_rdata,
    output logic                       done_valid,
    output logic                       fault_valid,
    output logic                       fault_level,
    output logic [ADDR_W-OFFS_W-1:0]   res_vpn,
    output logic [ADDR_W-OFFS_W-1:0]   res_ppn,
    output logic                       res_writable,
    output logic                       res_user,
    output logic                       res_dirty
);
    localparam int PN_W = ADDR_W - OFFS_W;

    walk_state_e        state;
    logic [PN_W-1:0]    vpn_q;
    logic               write_q;
    logic [PN_W-1:0]    dir_pn_q;
    logic [ADDR_W-1:0]  leaf_q;
    logic               lvl_q;

    logic               rd_present;
    logic [PN_W-1:0]    rd_pn;
    logic [ADDR_W-1:0]  rd_upd;
    logic               rd_wb_needed;
    logic [ADDR_W-1:0]  ent_addr;

    ptw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .mem_ack     (mem_ack),
        .ent_present (rd_present),
        .wb_needed   (rd_wb_needed),
        .state       (state)
    );

    ptw_entry_upd #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_upd (
        .ent       (mem_rdata),
        .is_write  (write_q),
        .present   (rd_present),
        .pn        (rd_pn),
        .upd       (rd_upd),
        .wb_needed (rd_wb_needed)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_addr (
        .leaf_level (state != ST_DIR_RD),
        .root_pn    (root_ppn),
        .dir_pn     (dir_pn_q),
        .vpn        (vpn_q),
        .ent_addr   (ent_addr)
    );

    // Walk context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q    <= '0;
            write_q  <= 1'b0;
            dir_pn_q <= '0;
            leaf_q   <= '0;
            lvl_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                vpn_q   <= req_vaddr[ADDR_W-1:OFFS_W];
                write_q <= req_write;
            end
            if (state == ST_DIR_RD && mem_ack) begin
                dir_pn_q <= rd_pn;
                lvl_q    <= 1'b0;
            end
            if (state == ST_TBL_RD && mem_ack) begin
                leaf_q <= rd_upd;
                lvl_q  <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy        = 1'b1;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        done_valid  = 1'b0;
        fault_valid = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_DIR_RD:  mem_req = 1'b1;
            ST_TBL_RD:  mem_req = 1'b1;
            ST_LEAF_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_DONE:    done_valid  = 1'b1;
            ST_FAULT:   fault_valid = 1'b1;
            default:    busy = 1'b1;
        endcase
    end

    assign mem_addr     = ent_addr;
    assign mem_wdata    = leaf_q;
    assign fault_level  = lvl_q;
    assign res_vpn      = vpn_q;
    assign res_ppn      = leaf_q[ADDR_W-1:OFFS_W];
    assign res_writable = leaf_q[ENT_WRITE];
    assign res_user     = leaf_q[ENT_USER];
    assign res_dirty    = leaf_q[ENT_DIRTY];

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              done_valid,
    input logic              fault_valid
);
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> !(done_valid || fault_valid) && !busy);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    p_req_in_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_wb_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .done_valid  (done_valid),
    .fault_valid (fault_valid)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_ppn = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid, fault_valid, fault_level;
    logic [19:0] res_vpn, res_ppn;
    logic        res_writable, res_user, res_dirty;

    always #4 clk = ~clk;  // 125 MHz

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .fault_valid(fault_valid), .fault_level(fault_level),
        .res_vpn(res_vpn), .res_ppn(res_ppn), .res_writable(res_writable),
        .res_user(res_user), .res_dirty(res_dirty)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_res = 0;
    int n_rd  = 0;
    int n_wr  = 0;
    logic [31:0] rd_log [4];

    logic [31:0] mem [logic [31:0]];

    typedef struct packed {
        logic        flt;
        logic        lvl;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic        w;
        logic        u;
        logic        d;
        logic        wb;
        logic [31:0] da;
        logic [31:0] ta;
        logic [31:0] nv;
    } exp_t;

    exp_t sb_q [$];

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Memory responder: variable latency, one access at a time
    int wait_cnt = 0;
    int lat = 0;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req && rst_n) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                lat = (lat + 1) % 3;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mrd(mem_addr);
                    if (n_rd < 4) rd_log[n_rd] = mem_addr;
                    n_rd++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // Monitor: compare results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (done_valid || fault_valid)) begin
            exp_t e;
            n_res++;
            chk(!(done_valid && fault_valid), "R12", "done and fault together",
                {31'b0, fault_valid}, 32'h0);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "result with no request", 32'h1, 32'h0);
            end else begin
                e = sb_q.pop_front();
                chk(fault_valid == e.flt, e.flt ? "R5" : "R7", "result kind",
                    {31'b0, fault_valid}, {31'b0, e.flt});
                chk(res_vpn == e.vpn, "R7", "vpn", {12'b0, res_vpn}, {12'b0, e.vpn});
                if (e.flt) begin
                    chk(fault_level == e.lvl, e.lvl ? "R6" : "R5", "fault level",
                        {31'b0, fault_level}, {31'b0, e.lvl});
                end else begin
                    chk(res_ppn == e.ppn, "R7", "ppn", {12'b0, res_ppn}, {12'b0, e.ppn});
                    chk(res_writable == e.w, "R7", "writable", {31'b0, res_writable}, {31'b0, e.w});
                    chk(res_user == e.u, "R7", "user", {31'b0, res_user}, {31'b0, e.u});
                    chk(res_dirty == e.d, "R9", "dirty", {31'b0, res_dirty}, {31'b0, e.d});
                end
            end
        end
    end

    task automatic do_walk(input logic [31:0] va, input logic wr, input bit inject);
        exp_t e;
        logic [31:0] de, te;
        int n0, w0, nreads, guard;
        e = '0;
        e.vpn = va[31:12];
        e.da  = {root_ppn, va[31:22], 2'b00};
        de = mrd(e.da);
        nreads = 1;
        if (!de[0]) begin
            e.flt = 1'b1; e.lvl = 1'b0;
        end else begin
            nreads = 2;
            e.ta = {de[31:12], va[21:12], 2'b00};
            te = mrd(e.ta);
            if (!te[0]) begin
                e.flt = 1'b1; e.lvl = 1'b1;
            end else begin
                e.nv = te | 32'h20 | (wr ? 32'h40 : 32'h0);
                e.wb = (e.nv != te);
                e.ppn = te[31:12];
                e.w = te[1]; e.u = te[2]; e.d = e.nv[6];
            end
        end
        sb_q.push_back(e);
        n0 = n_res; w0 = n_wr; n_rd = 0;
        guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            @(negedge clk);
            chk(busy == 1'b1, "R2", "busy during walk", {31'b0, busy}, 32'h1);
            req_valid = 1'b1; req_vaddr = 32'h0080_0000; req_write = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (n_res == n0 && guard < 1000) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        chk(n_res == n0 + 1, "R2", "one result per accepted request", n_res - n0, 1);
        chk(!busy, "R2", "idle after result", {31'b0, busy}, 32'h0);
        chk(n_rd == nreads, e.flt && !e.lvl ? "R5" : "R4", "read count", n_rd, nreads);
        chk(rd_log[0] == e.da, "R3", "directory address", rd_log[0], e.da);
        if (nreads == 2)
            chk(rd_log[1] == e.ta, "R4", "leaf address", rd_log[1], e.ta);
        if (e.flt) begin
            chk(n_wr == w0, "R6", "no write on fault", n_wr - w0, 0);
        end else if (e.wb) begin
            chk(n_wr == w0 + 1, "R8", "write-back made", n_wr - w0, 1);
            chk(mrd(e.ta) == e.nv, wr ? "R9" : "R8", "written leaf", mrd(e.ta), e.nv);
        end else begin
            chk(n_wr == w0, "R10", "write-back skipped", n_wr - w0, 0);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // Table contents, root page 0x00100
        mem[32'h0010_0004] = 32'h0030_0001;  // dir idx 1 -> table 0x00300
        mem[32'h0030_000C] = 32'h1234_5007;  // P W U, flags clear
        mem[32'h0010_0008] = 32'hFFFF_FFFE;  // dir idx 2 absent, junk bits
        mem[32'h0030_0014] = 32'hABCD_E0FE;  // leaf absent, junk bits
        mem[32'h0010_0FFC] = 32'h0040_0001;  // dir idx 1023
        mem[32'h0040_0FFC] = 32'h0000_1001;  // read-only leaf
        mem[32'h0010_0000] = 32'h0050_0003;  // dir idx 0
        mem[32'h0050_0000] = 32'h0007_7061;  // A and D already set
        mem[32'h0020_0004] = 32'h0060_0001;  // second root, dir idx 1
        mem[32'h0060_000C] = 32'h0000_A025;  // P U A
        root_ppn = 20'h00100;

        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done_valid && !fault_valid, "R1", "reset outputs",
            {28'b0, busy, mem_req, done_valid, fault_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset", {30'b0, busy, mem_req}, 32'h0);

        do_walk(32'h0040_3123, 1'b0, 1'b0);  // sets accessed (R8)
        do_walk(32'h0040_3123, 1'b1, 1'b0);  // sets dirty (R9)
        do_walk(32'h0040_3123, 1'b0, 1'b0);  // skip (R10)
        do_walk(32'h0040_3123, 1'b1, 1'b0);  // skip (R10)
        do_walk(32'h0080_0000, 1'b0, 1'b0);  // directory absent (R5)
        do_walk(32'h0040_5000, 1'b1, 1'b0);  // leaf absent (R6)
        do_walk(32'hFFFF_FFFF, 1'b1, 1'b0);  // top indices, write on RO leaf
        do_walk(32'h0000_0000, 1'b0, 1'b0);  // bottom indices, no write-back
        do_walk(32'h0000_0ABC, 1'b1, 1'b1);  // request during walk ignored (R2)
        root_ppn = 20'h00200;
        do_walk(32'h0040_3FFF, 1'b0, 1'b0);  // other root (R3)

        chk(sb_q.size() == 0, "R12", "scoreboard drained", sb_q.size(), 0);
        summary();
    end

endmodule